// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a position count from a two-channel incremental encoder. The two channels, A and B, are asynchronous pins. Each passes through a synchronizer, and the block then looks for level changes on it. A two-bit function field picks how those changes become counts:

- Function 0 ignores the encoder and counts one per clock while enabled.
- Function 1 counts on every edge of A, with B giving the sense.
- Function 2 counts on every edge of B, with A giving the sense.
- Function 3 counts on every edge of either channel, which gives four counts per encoder period.

The count runs from zero up to a programmable ceiling and wraps at both ends. The ceiling can be written directly, or it can be staged in a shadow copy. In that case the shadow moves to the active ceiling on a software update event or on a counter wrap, so the period can change without a glitch.

Software reaches the block through a four-word register port. Writes are synchronous. Reads are a combinational decode of the address. The word width is the counter width.

Top module: `qenc_top`

## Requirements
- R1: After reset the count is 0, the active ceiling is all ones, and the control word (address 0) reads 0. Address 3 reads 0.
- R2: With function 0 (control bits [3:2]) and enable (control bit 0) set, the count rises by exactly one per clock.
- R3: Function 1 changes the count on each rising and falling edge of A. It counts up when, after the edge, A differs from B, and down otherwise. Edges of B leave the count unchanged.
- R4: Function 2 changes the count on each edge of B. It counts up when, after the edge, A equals B, and down otherwise. Edges of A leave the count unchanged.
- R5: Function 3 counts on edges of both channels. The sequence AB = 00,10,11,01,00 adds four, and the reverse sequence subtracts four.
- R6: While enable is clear, the count holds its value in every function.
- R7: Control bit 4 reads 1 when the last step was downward and 0 when it was upward. Writes to bit 4 have no effect.
- R8: A step up from a count at or above the ceiling gives 0. A step down from 0 gives the ceiling.
- R9: With preload (control bit 1) clear, a write to address 2 changes the active ceiling at once. Address 2 reads the active ceiling.
- R10: With preload set, a write to address 2 goes only to the shadow. The shadow is copied to the active ceiling on a software update event or on a counter wrap.
- R11: Writing 1 to bit 0 of address 3 raises a single-cycle update event. Address 3 always reads 0.
- R12: A write to address 1 presets the count to the written value.
- R13: When A and B both change in the same sampled cycle, the count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 count, 2 ceiling, 3 event) |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Read data for addr |
| encA | input | 1 | Encoder channel A, asynchronous |
| encB | input | 1 | Encoder channel B, asynchronous |

## Verification
The bench walks full encoder cycles forwards and backwards in each function. In the single-channel functions it also toggles the ignored channel. A design that swapped the sense rule, or that counted the wrong channel, would drift on these walks.

Both ends of the range are tested. The count is preset to the ceiling and then stepped up, and from 0 it is stepped down. An off-by-one wrap or a wrong reload value shows up in the count that is read back.

Preload is tested on both of its load paths: the software event and a wrap. A design that wrote the ceiling through while preload was set would show the new ceiling too early.

A diagonal jump of both channels in one cycle must leave the count untouched. A design that treated it as two steps would show a changed count.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CEIL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_EVENT = 2'd3;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_EDGE_A = 2'd1,
    MODE_EDGE_B = 2'd2,
    MODE_BOTH   = 2'd3
  } qencMode_e;

  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic presetCnt;
    logic wrShadow;
    logic wrActive;
    logic swUpdate;
    logic stepUp;
    logic stepDown;
  } qencStrobe_t;

endpackage

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [3:0]          ctrlData,
  input  logic                encA,
  input  logic                encB,
  input  logic [CNT_W-1:0]    countQ,
  input  logic [CNT_W-1:0]    ceilQ,
  input  logic                dirQ,
  output logic [CNT_W-1:0]    rdData,
  output logic                enableQ,
  output qencStrobe_t         stb
);

  localparam int PAD_W = CNT_W - 5;

  logic      preloadQ;
  qencMode_e modeQ;

  logic [SYNC_STAGES-1:0] syncA, syncB;
  logic aNow, bNow, aPrev, bPrev;
  logic aEdge, bEdge;
  logic wantUp, wantDown;

  // Control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      preloadQ <= 1'b0;
      modeQ    <= MODE_FREE;
    end else if (wrEn && addr == ADDR_CTRL) begin
      enableQ  <= ctrlData[0];
      preloadQ <= ctrlData[1];
      modeQ    <= qencMode_e'(ctrlData[3:2]);
    end
  end

  // Input synchronizers and edge memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      aPrev <= 1'b0;
      bPrev <= 1'b0;
    end else begin
      syncA <= {syncA[SYNC_STAGES-2:0], encA};
      syncB <= {syncB[SYNC_STAGES-2:0], encB};
      aPrev <= aNow;
      bPrev <= bNow;
    end
  end

  assign aNow  = syncA[SYNC_STAGES-1];
  assign bNow  = syncB[SYNC_STAGES-1];
  assign aEdge = aNow ^ aPrev;
  assign bEdge = bNow ^ bPrev;

  // Step decode; a change on both channels at once is discarded
  always_comb begin
    wantUp   = 1'b0;
    wantDown = 1'b0;
    unique case (modeQ)
      MODE_FREE: wantUp = 1'b1;
      MODE_EDGE_A: begin
        if (aEdge && !bEdge) begin
          wantUp   = (aNow != bNow);
          wantDown = (aNow == bNow);
        end
      end
      MODE_EDGE_B: begin
        if (bEdge && !aEdge) begin
          wantUp   = (aNow == bNow);
          wantDown = (aNow != bNow);
        end
      end
      MODE_BOTH: begin
        if (aEdge && !bEdge) begin
          wantUp   = (aNow != bNow);
          wantDown = (aNow == bNow);
        end else if (bEdge && !aEdge) begin
          wantUp   = (aNow == bNow);
          wantDown = (aNow != bNow);
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    stb.presetCnt = wrEn && addr == ADDR_COUNT;
    stb.wrShadow  = wrEn && addr == ADDR_CEIL;
    stb.wrActive  = wrEn && addr == ADDR_CEIL && !preloadQ;
    stb.swUpdate  = wrEn && addr == ADDR_EVENT && ctrlData[0];
    stb.stepUp    = enableQ && wantUp;
    stb.stepDown  = enableQ && wantDown;
  end

  // Read decode
  always_comb begin
    unique case (addr)
      ADDR_CTRL:  rdData = {{PAD_W{1'b0}}, dirQ, modeQ, preloadQ, enableQ};
      ADDR_COUNT: rdData = countQ;
      ADDR_CEIL:  rdData = ceilQ;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] wrData,
  input  qencStrobe_t      stb,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] ceilQ,
  output logic             dirQ
);

  logic [CNT_W-1:0] shadowQ;
  logic             wrapUp, wrapDown, wrapAny;

  assign wrapUp   = stb.stepUp   && !stb.presetCnt && (countQ >= ceilQ);
  assign wrapDown = stb.stepDown && !stb.presetCnt && (countQ == '0);
  assign wrapAny  = wrapUp || wrapDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      dirQ   <= 1'b0;
    end else if (stb.presetCnt) begin
      countQ <= wrData;
    end else if (stb.stepUp) begin
      countQ <= wrapUp ? '0 : countQ + 1'b1;
      dirQ   <= 1'b0;
    end else if (stb.stepDown) begin
      countQ <= wrapDown ? ceilQ : countQ - 1'b1;
      dirQ   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '1;
      ceilQ   <= '1;
    end else begin
      if (stb.wrShadow) shadowQ <= wrData;
      if (stb.wrActive)                  ceilQ <= wrData;
      else if (stb.swUpdate || wrapAny)  ceilQ <= shadowQ;
    end
  end

endmodule

// File: rtl/qenc_top.sv
module qenc_top
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              encA,
  input  logic              encB
);

  qencStrobe_t      stb;
  logic [CNT_W-1:0] countQ, ceilQ;
  logic             dirQ, enableQ;

  qenc_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .ctrlData(wrData[3:0]), .encA(encA), .encB(encB),
    .countQ(countQ), .ceilQ(ceilQ), .dirQ(dirQ),
    .rdData(rdData), .enableQ(enableQ), .stb(stb)
  );

  qenc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stb(stb),
    .countQ(countQ), .ceilQ(ceilQ), .dirQ(dirQ)
  );

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] countQ,
  input logic [CNT_W-1:0] ceilQ,
  input logic             dirQ,
  input logic             enableQ,
  input qencStrobe_t      stb
);

  assert_hold_when_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && !stb.presetCnt) |=> $stable(countQ));

  assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepUp && !stb.presetCnt && countQ == ceilQ) |=> (countQ == '0));

  assert_wrap_down_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepDown && !stb.presetCnt && countQ == '0) |=> (countQ == $past(ceilQ)));

  assert_one_sense_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.stepUp, stb.stepDown}));

  assert_dir_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepDown && !stb.presetCnt) |=> dirQ);

  assert_preload_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrShadow && !stb.wrActive && !stb.swUpdate && !stb.stepUp && !stb.stepDown)
      |=> $stable(ceilQ));

  assert_preset_R12: assert property (@(posedge clk) disable iff (!rstN)
    stb.presetCnt |=> (countQ == $past(wrData)));

endmodule

bind qenc_top qenc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrData(wrData), .countQ(countQ), .ceilQ(ceilQ),
  .dirQ(dirQ), .enableQ(enableQ), .stb(stb)
);

// File: tb/qenc_top_tb_top.sv
module qenc_top_tb_top;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       addr = 2'd0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] rdData;
  logic             encA = 1'b0;
  logic             encB = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  qenc_top #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .encA(encA), .encB(encB)
  );

  // Scoreboard queues
  logic [CNT_W-1:0] expQ[$];
  string            tagQ[$];
  event             sampleEv;

  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        logic [CNT_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", t, addr, rdData, e);
        end
      end
    end
  end

  // Reference model state
  int unsigned mCnt = 0, mCeil = 16'hFFFF, mShadow = 16'hFFFF;
  bit mEn = 0, mPre = 0, mDir = 0;
  int mMode = 0;

  function automatic logic [CNT_W-1:0] ctrlWord();
    return CNT_W'({mDir, 2'(mMode), mPre, mEn});
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [CNT_W-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input logic [CNT_W-1:0] e, input string tag);
    addr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    #1;
    ->sampleEv;
    #1;
    @(negedge clk);
  endtask

  task automatic setCtrl(input bit en, input bit pre, input int mode);
    mEn = en; mPre = pre; mMode = mode;
    writeReg(2'd0, CNT_W'({2'(mode), pre, en}));
  endtask

  task automatic setCeil(input int unsigned v);
    mShadow = v;
    if (!mPre) mCeil = v;
    writeReg(2'd2, CNT_W'(v));
  endtask

  task automatic setCount(input int unsigned v);
    mCnt = v;
    writeReg(2'd1, CNT_W'(v));
  endtask

  task automatic stepModel(input bit up);
    if (up) begin
      mDir = 0;
      if (mCnt >= mCeil) begin mCnt = 0; mCeil = mShadow; end
      else mCnt++;
    end else begin
      mDir = 1;
      if (mCnt == 0) begin mCnt = mCeil; mCeil = mShadow; end
      else mCnt--;
    end
  endtask

  // Move the encoder pins; the model applies the function rules
  task automatic quadMove(input bit na, input bit nb);
    bit aE, bE;
    aE = (na != encA);
    bE = (nb != encB);
    if (mEn && !(aE && bE)) begin
      if (aE && (mMode == 1 || mMode == 3)) stepModel(na != nb);
      if (bE && (mMode == 2 || mMode == 3)) stepModel(na == nb);
    end
    encA = na; encB = nb;
    repeat (5) @(negedge clk);
  endtask

  task automatic forwardCycle();
    quadMove(1, 0); quadMove(1, 1); quadMove(0, 1); quadMove(0, 0);
  endtask

  task automatic reverseCycle();
    quadMove(0, 1); quadMove(1, 1); quadMove(1, 0); quadMove(0, 0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectRead(2'd0, '0, "R1 ctrl");
    expectRead(2'd1, '0, "R1 count");
    expectRead(2'd2, 16'hFFFF, "R1 ceiling");
    expectRead(2'd3, '0, "R1 event");

    // R2 free counting: enabled for ten clock edges
    writeReg(2'd0, 16'h0001);
    repeat (9) @(negedge clk);
    writeReg(2'd0, 16'h0000);
    mCnt = 10;
    expectRead(2'd1, CNT_W'(mCnt), "R2 free count");
    expectRead(2'd0, ctrlWord(), "R7 dir after free count");

    // R6 hold while disabled
    repeat (6) @(negedge clk);
    expectRead(2'd1, CNT_W'(mCnt), "R6 hold");

    // R12 preset
    setCount(100);
    expectRead(2'd1, 16'd100, "R12 preset");

    // R5 both channels
    setCtrl(1, 0, 3);
    forwardCycle();
    expectRead(2'd1, 16'd104, "R5 forward x4");
    expectRead(2'd0, ctrlWord(), "R7 dir up");
    reverseCycle();
    expectRead(2'd1, 16'd100, "R5 reverse x4");
    expectRead(2'd0, ctrlWord(), "R7 dir down");

    // R13 simultaneous change ignored
    quadMove(1, 1);
    expectRead(2'd1, 16'd100, "R13 diagonal up");
    quadMove(0, 0);
    expectRead(2'd1, 16'd100, "R13 diagonal back");

    // R3 channel A only
    setCtrl(1, 0, 1);
    forwardCycle();
    expectRead(2'd1, 16'd102, "R3 forward x2 on A");
    reverseCycle();
    expectRead(2'd1, 16'd100, "R3 reverse x2 on A");
    quadMove(0, 1); quadMove(0, 0);
    expectRead(2'd1, 16'd100, "R3 B edges ignored");

    // R4 channel B only
    setCtrl(1, 0, 2);
    forwardCycle();
    expectRead(2'd1, 16'd102, "R4 forward x2 on B");
    quadMove(1, 0); quadMove(0, 0);
    expectRead(2'd1, 16'd102, "R4 A edges ignored");

    // R6 disabled with encoder activity
    setCtrl(0, 0, 3);
    forwardCycle();
    expectRead(2'd1, 16'd102, "R6 hold with edges");

    // R9 immediate ceiling, R8 wraps
    setCeil(5);
    expectRead(2'd2, 16'd5, "R9 immediate ceiling");
    setCount(5);
    setCtrl(1, 0, 3);
    quadMove(1, 0);
    expectRead(2'd1, CNT_W'(mCnt), "R8 wrap up to zero");
    quadMove(0, 0);
    expectRead(2'd1, CNT_W'(mCnt), "R8 wrap down to ceiling");
    expectRead(2'd0, ctrlWord(), "R7 dir after wrap down");

    // R10 preload via software event, R11 event bit
    setCtrl(0, 1, 0);
    setCeil(9);
    expectRead(2'd2, 16'd5, "R10 shadow not active");
    writeReg(2'd3, 16'h0001);
    mCeil = mShadow;
    expectRead(2'd2, 16'd9, "R10 loaded on update event");
    expectRead(2'd3, '0, "R11 event reads zero");

    // R10 preload via wrap
    setCeil(3);
    expectRead(2'd2, 16'd9, "R10 shadow pending");
    setCount(9);
    setCtrl(1, 1, 3);
    quadMove(1, 0);
    expectRead(2'd1, CNT_W'(mCnt), "R10 wrap count");
    expectRead(2'd2, CNT_W'(mCeil), "R10 loaded on wrap");

    // R7 direction bit is not writable
    mEn = 0; mPre = 0; mMode = 0;
    writeReg(2'd0, 16'h0010);
    expectRead(2'd0, ctrlWord(), "R7 dir write ignored");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule